// File: doc/BRIEF.md
# Prioritised Restart Interrupt Controller

This block sits beside a processor core's instruction sequencer and decides, once per instruction, whether an interrupt is taken and which one. Five request lines feed it: a non-maskable line, three restart lines (one edge-captured, two level-sensitive) and a general request whose vector comes from an external device. The core pulses a strobe in the clock before the last clock of each instruction. Requests are evaluated only on that strobe.

When a request wins, the block pulses an accept signal for one clock. In the same clock it holds the program counter from advancing and presents either a fixed 16-bit restart address or an acknowledge request. With the acknowledge request, an external device places a restart or call opcode on the bus, using the same timing as a read. The core's enable/disable instructions and its mask-load instruction appear here as simple strobes and a write port. The global enable, the masks and the raw pending lines can be read back as outputs, as the core's read-mask instruction would do.

Top module: `intc_top`

## Requirements
- R1: After reset, take_o, inta_o, pc_hold_o and vec_o are 0, ie_o is 0, mask_o is 3'b111 (all restart lines masked) and the edge latch is clear. A line that is already high when reset ends does not count as a rising edge.
- R2: When several lines are eligible at once, the winner is chosen in fixed order: nmi_i first, then edge_req_i, then lvl_a_i, then lvl_b_i, then ext_req_i.
- R3: nmi_i is taken regardless of ie_o and regardless of every mask bit.
- R4: Requests are evaluated only on a clock edge where sample_i is 1. The accept outputs (take_o, pc_hold_o, inta_o, vec_o) are registered and are valid for the one clock after that edge. With sample_i at 0, take_o stays 0 in the following clock.
- R5: When ext_req_i wins, inta_o and pc_hold_o go to 1 and vec_o is 0.
- R6: When a restart line wins, inta_o stays 0, pc_hold_o is 1, and vec_o carries that line's fixed address: nmi_i 16'h0024, edge_req_i 16'h003C, lvl_a_i 16'h0034, lvl_b_i 16'h002C.
- R7: A pulse on ie_set_i sets ie_o and a pulse on ie_clr_i clears it. Accepting any maskable line clears ie_o on the accept edge, and this takes priority over ie_set_i. Accepting nmi_i leaves ie_o unchanged. Maskable lines are eligible only while ie_o is 1.
- R8: A rising edge on edge_req_i sets a latch that is visible on pend_o[2]. The latch records edges even while the line is masked. It clears when that line is accepted, or on a mask write with mask_wdata_i[3]=1. A new rising edge in the same clock as either clear wins over the clear.
- R9: lvl_a_i and lvl_b_i are level-sensitive. Only their level on the sampling edge counts, and pend_o[1] and pend_o[0] show them directly.
- R10: nmi_i is eligible only after a rising edge, while the line is still high at the sampling edge. Once taken, it is not taken again until the line falls and rises again. An edge that falls before the sampling edge is lost.
- R11: mask_we_i loads mask_o from mask_wdata_i[2:0]: bit 2 masks edge_req_i, bit 1 masks lvl_a_i, bit 0 masks lvl_b_i, and 1 means masked. A masked line is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request, edge-armed |
| edge_req_i | input | 1 | Highest maskable restart request, rising-edge captured |
| lvl_a_i | input | 1 | Middle restart request, level |
| lvl_b_i | input | 1 | Lowest restart request, level |
| ext_req_i | input | 1 | General request, vector supplied externally |
| sample_i | input | 1 | Strobe from the core: next-to-last clock of an instruction |
| ie_set_i | input | 1 | Enable-interrupts instruction strobe |
| ie_clr_i | input | 1 | Disable-interrupts instruction strobe |
| mask_we_i | input | 1 | Mask-load instruction strobe |
| mask_wdata_i | input | 4 | [2:0] new mask bits, [3] clears the edge latch |
| take_o | output | 1 | One-clock accept pulse |
| inta_o | output | 1 | Request an external vector fetch cycle |
| pc_hold_o | output | 1 | Inhibit the program counter increment |
| vec_o | output | 16 | Restart address, 0 when none or external |
| ie_o | output | 1 | Global interrupt enable |
| mask_o | output | 3 | Current restart masks |
| pend_o | output | 3 | {edge latch, lvl_a_i, lvl_b_i} |

## Verification
A stuck or stale edge latch appears on pend_o[2] one clock after the event that should have changed it. It also produces an extra or missing accept at the next sampling strobe. A wrong enable flag appears on ie_o within one clock of an accept or an enable strobe. The nmi arming state has no output of its own, so an error there shows only at the next strobe: a repeated non-maskable accept, or one that never comes. The reference model is compared with every output on every clock, so any such divergence is reported in the clock where it first reaches a port.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int NSRC  = 5;  // nmi, edge, lvl_a, lvl_b, ext
  localparam int MASKW = 3;  // masks for edge, lvl_a, lvl_b

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_EDGE = 3'd2,
    SRC_LVLA = 3'd3,
    SRC_LVLB = 3'd4,
    SRC_EXT  = 3'd5
  } src_e;

  // elig[4]=nmi, [3]=edge, [2]=lvl_a, [1]=lvl_b, [0]=ext; higher bit wins
  function automatic src_e pick_src(input logic [NSRC-1:0] elig);
    src_e s;
    s = SRC_NONE;
    if (elig[4])      s = SRC_NMI;
    else if (elig[3]) s = SRC_EDGE;
    else if (elig[2]) s = SRC_LVLA;
    else if (elig[1]) s = SRC_LVLB;
    else if (elig[0]) s = SRC_EXT;
    return s;
  endfunction

  function automatic logic is_maskable(input src_e s);
    return (s != SRC_NONE) && (s != SRC_NMI);
  endfunction

endpackage

// File: rtl/intc_edge_cap.sv
// Rising-edge capture. STICKY=1: the flag holds until cleared.
// STICKY=0: the flag also drops as soon as the input goes low.
module intc_edge_cap #(
  parameter bit STICKY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  input  logic clr_i,
  output logic q_o
);

  logic prev_q;
  logic rise;
  logic q_n;

  assign rise = in_i & ~prev_q;

  generate
    if (STICKY) begin : g_sticky
      assign q_n = (q_o & ~clr_i) | rise;
    end else begin : g_armed
      assign q_n = (q_o & in_i & ~clr_i) | rise;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;  // a level present at reset is not an edge
      q_o    <= 1'b0;
    end else begin
      prev_q <= in_i;
      q_o    <= q_n;
    end
  end

  // R8 / R10: a clear without a concurrent new edge empties the flag
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(in_i && !prev_q)) |=> !q_o);

endmodule

// File: rtl/intc_ctl_regs.sv
module intc_ctl_regs #(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ie_set_i,
  input  logic          ie_clr_i,
  input  logic          drop_i,     // a maskable line was accepted
  input  logic          we_i,
  input  logic [MW-1:0] wdata_i,
  output logic          ie_o,
  output logic [MW-1:0] mask_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_o   <= 1'b0;
      mask_o <= '1;
    end else begin
      if (drop_i)        ie_o <= 1'b0;
      else if (ie_clr_i) ie_o <= 1'b0;
      else if (ie_set_i) ie_o <= 1'b1;
      if (we_i) mask_o <= wdata_i;
    end
  end

  p_ie_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> !ie_o);

  p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_o == $past(wdata_i)));

endmodule

// File: rtl/intc_prio.sv
module intc_prio
  import intc_pkg::*;
(
  input  logic [NSRC-1:0] elig_i,
  output src_e            src_o
);

  always_comb src_o = pick_src(elig_i);

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int                 VEC_W    = 16,
  parameter logic [VEC_W-1:0]   VEC_NMI  = 16'h0024,
  parameter logic [VEC_W-1:0]   VEC_EDGE = 16'h003C,
  parameter logic [VEC_W-1:0]   VEC_LVLA = 16'h0034,
  parameter logic [VEC_W-1:0]   VEC_LVLB = 16'h002C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_i,
  input  logic             edge_req_i,
  input  logic             lvl_a_i,
  input  logic             lvl_b_i,
  input  logic             ext_req_i,
  input  logic             sample_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             mask_we_i,
  input  logic [MASKW:0]   mask_wdata_i,
  output logic             take_o,
  output logic             inta_o,
  output logic             pc_hold_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ie_o,
  output logic [MASKW-1:0] mask_o,
  output logic [MASKW-1:0] pend_o
);

  localparam int CLR_BIT = MASKW;

  function automatic logic [VEC_W-1:0] vec_of(input src_e s);
    case (s)
      SRC_NMI:  return VEC_NMI;
      SRC_EDGE: return VEC_EDGE;
      SRC_LVLA: return VEC_LVLA;
      SRC_LVLB: return VEC_LVLB;
      default:  return '0;
    endcase
  endfunction

  // named internal events
  logic             nmi_arm;
  logic             edge_lat;
  logic [NSRC-1:0]  elig;
  src_e             pick;
  logic             accept;
  logic             accept_nmi;
  logic             accept_edge;
  logic             accept_mask;
  logic             edge_clr;
  logic             ie_q;
  logic [MASKW-1:0] mask_q;

  assign accept      = sample_i && (pick != SRC_NONE);
  assign accept_nmi  = accept && (pick == SRC_NMI);
  assign accept_edge = accept && (pick == SRC_EDGE);
  assign accept_mask = accept && is_maskable(pick);
  assign edge_clr    = accept_edge || (mask_we_i && mask_wdata_i[CLR_BIT]);

  intc_edge_cap #(.STICKY(1'b0)) u_nmi_cap (
    .clk(clk), .rst_n(rst_n), .in_i(nmi_i), .clr_i(accept_nmi), .q_o(nmi_arm)
  );

  intc_edge_cap #(.STICKY(1'b1)) u_edge_cap (
    .clk(clk), .rst_n(rst_n), .in_i(edge_req_i), .clr_i(edge_clr), .q_o(edge_lat)
  );

  intc_ctl_regs #(.MW(MASKW)) u_regs (
    .clk(clk), .rst_n(rst_n), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
    .drop_i(accept_mask), .we_i(mask_we_i), .wdata_i(mask_wdata_i[MASKW-1:0]),
    .ie_o(ie_q), .mask_o(mask_q)
  );

  assign elig = { nmi_arm & nmi_i,
                  ie_q & edge_lat  & ~mask_q[2],
                  ie_q & lvl_a_i   & ~mask_q[1],
                  ie_q & lvl_b_i   & ~mask_q[0],
                  ie_q & ext_req_i };

  intc_prio u_prio (.elig_i(elig), .src_o(pick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o <= 1'b0;
      inta_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      take_o <= accept;
      inta_o <= accept && (pick == SRC_EXT);
      vec_o  <= accept ? vec_of(pick) : '0;
    end
  end

  assign pc_hold_o = take_o;
  assign ie_o      = ie_q;
  assign mask_o    = mask_q;
  assign pend_o    = {edge_lat, lvl_a_i, lvl_b_i};

  // R4: accepts only follow a sampling edge
  p_idle_no_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> !take_o);

  // R5: external vector form
  p_inta_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |-> (pc_hold_o && vec_o == '0));

  // R6: internal restart always carries an address
  p_restart_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !inta_o) |-> (vec_o != '0));

  // R3: an armed, still-high nmi wins whatever enable and masks say
  p_nmi_blind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && nmi_arm && nmi_i) |=> (take_o && vec_o == VEC_NMI));

  // R7: maskable accepts require the enable one clock earlier
  p_ie_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o != VEC_NMI) |-> $past(ie_q));

  // R2: the winner is never below an eligible higher line
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && elig[3] && !elig[4]) |=> (vec_o == VEC_EDGE));

endmodule

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;

  localparam logic [15:0] A_NMI = 16'h0024, A_EDGE = 16'h003C,
                          A_LA  = 16'h0034, A_LB   = 16'h002C;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n, nmi, edg, la, lb, ext, smp, ies, iec, mwe;
  logic [3:0] mwd;
  logic take_o, inta_o, pc_hold_o, ie_o;
  logic [15:0] vec_o;
  logic [2:0] mask_o, pend_o;

  intc_top dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .edge_req_i(edg), .lvl_a_i(la),
    .lvl_b_i(lb), .ext_req_i(ext), .sample_i(smp), .ie_set_i(ies),
    .ie_clr_i(iec), .mask_we_i(mwe), .mask_wdata_i(mwd), .take_o(take_o),
    .inta_o(inta_o), .pc_hold_o(pc_hold_o), .vec_o(vec_o), .ie_o(ie_o),
    .mask_o(mask_o), .pend_o(pend_o)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", t, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_ie, m_lat, m_eprev, m_arm, m_nprev, o_take, o_inta;
  bit [2:0] m_mask;
  logic [15:0] o_vec;
  always @(posedge clk) begin
    int w;
    if (!rst_n) begin
      m_ie = 0; m_mask = 3'b111; m_lat = 0; m_eprev = 1; m_arm = 0; m_nprev = 1;
      o_take = 0; o_inta = 0; o_vec = 0;
    end else begin
      w = -1;
      if (smp) begin
        if (m_arm && nmi)                     w = 0;
        else if (m_ie && m_lat && !m_mask[2]) w = 1;
        else if (m_ie && la && !m_mask[1])    w = 2;
        else if (m_ie && lb && !m_mask[0])    w = 3;
        else if (m_ie && ext)                 w = 4;
      end
      o_take = (w >= 0);
      o_inta = (w == 4);
      case (w)
        0: o_vec = A_NMI;  1: o_vec = A_EDGE;
        2: o_vec = A_LA;   3: o_vec = A_LB;
        default: o_vec = 0;
      endcase
      if (w >= 1) m_ie = 0; else if (iec) m_ie = 0; else if (ies) m_ie = 1;
      if (w == 1) m_lat = 0;
      if (mwe && mwd[3]) m_lat = 0;
      if (edg && !m_eprev) m_lat = 1;
      m_eprev = edg;
      if (!nmi) m_arm = 0;
      if (nmi && !m_nprev) m_arm = 1;
      if (w == 0) m_arm = 0;
      m_nprev = nmi;
      if (mwe) m_mask = mwd[2:0];
    end
  end

  bit cmp_on = 0;
  always @(posedge clk) begin
    #5;
    if (cmp_on && !done) begin
      chk(tag, "take", take_o, o_take);
      chk(tag, "inta", inta_o, o_inta);
      chk(tag, "hold", pc_hold_o, o_take);
      chk(tag, "vec", vec_o, o_vec);
      chk(tag, "ie", ie_o, m_ie);
      chk(tag, "mask", mask_o, m_mask);
      chk(tag, "pend", pend_o, {m_lat, la, lb});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_sample();
    @(negedge clk); smp = 1;
    @(negedge clk); smp = 0;
    #1;
  endtask

  task automatic ie_on();
    @(negedge clk); ies = 1;
    @(negedge clk); ies = 0;
  endtask

  task automatic mwrite(input logic [3:0] d);
    @(negedge clk); mwe = 1; mwd = d;
    @(negedge clk); mwe = 0; mwd = 0;
  endtask

  task automatic expect_take(input string t, input logic [15:0] v, input logic ia);
    chk(t, "take", take_o, 1'b1);
    chk(t, "vec", vec_o, v);
    chk(t, "inta", inta_o, ia);
    chk(t, "hold", pc_hold_o, 1'b1);
  endtask

  initial begin
    rst_n = 0; nmi = 0; edg = 0; la = 0; lb = 0; ext = 0; smp = 0;
    ies = 0; iec = 0; mwe = 0; mwd = 0;
    cyc(3); #1;
    tag = "R1";
    chk("R1", "take", take_o, 0); chk("R1", "ie", ie_o, 0);
    chk("R1", "mask", mask_o, 3'b111); chk("R1", "vec", vec_o, 0);
    cmp_on = 1;
    nmi = 1;  // already high when reset ends: not an edge
    @(negedge clk); rst_n = 1;
    do_sample(); chk("R1", "nmi-at-reset take", take_o, 0);
    @(negedge clk); nmi = 0;

    tag = "R3";
    @(negedge clk); nmi = 1;
    do_sample(); expect_take("R3", A_NMI, 0);
    tag = "R10";
    do_sample(); chk("R10", "held nmi retaken", take_o, 0);
    @(negedge clk); nmi = 0;
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
    do_sample(); chk("R10", "lost nmi pulse", take_o, 0);

    tag = "R11";
    ie_on(); #1; chk("R7", "ie set", ie_o, 1);
    la = 1;
    do_sample(); chk("R11", "masked level", take_o, 0);
    chk("R9", "pend level", pend_o[1], 1);

    tag = "R2";
    mwrite(4'b0000);
    @(negedge clk); lb = 1; ext = 1; edg = 1;
    do_sample(); expect_take("R2", A_EDGE, 0);
    chk("R7", "ie drop", ie_o, 0);
    chk("R8", "latch cleared by accept", pend_o[2], 0);
    ie_on(); do_sample(); expect_take("R2", A_LA, 0);
    @(negedge clk); la = 0;
    ie_on(); do_sample(); expect_take("R6", A_LB, 0);
    @(negedge clk); lb = 0;
    ie_on(); do_sample(); expect_take("R5", 16'h0000, 1);
    @(negedge clk); ext = 0; edg = 0;

    tag = "R8";
    mwrite(4'b0100);
    @(negedge clk); edg = 1;
    @(negedge clk); edg = 0;
    ie_on(); do_sample(); chk("R8", "masked edge", take_o, 0);
    chk("R8", "latched while masked", pend_o[2], 1);
    mwrite(4'b1100); #1; chk("R8", "mask clear bit", pend_o[2], 0);
    mwrite(4'b0000);
    do_sample(); chk("R8", "cleared latch not taken", take_o, 0);

    tag = "R4";
    @(negedge clk); ext = 1;
    cyc(3); #1; chk("R4", "no strobe", take_o, 0);
    do_sample(); expect_take("R4", 16'h0000, 1);
    @(negedge clk); ext = 0;

    tag = "R7";
    ie_on();
    @(negedge clk); nmi = 1;
    do_sample(); expect_take("R7", A_NMI, 0);
    chk("R7", "nmi keeps ie", ie_o, 1);
    @(negedge clk); nmi = 0; iec = 1;
    @(negedge clk); iec = 0; #1;
    chk("R7", "ie clear", ie_o, 0);

    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      smp = ($urandom_range(0, 3) == 0);
      ies = ($urandom_range(0, 4) == 0);
      iec = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 9) == 0) nmi = ~nmi;
      if ($urandom_range(0, 5) == 0) edg = ~edg;
      if ($urandom_range(0, 7) == 0) la = ~la;
      if ($urandom_range(0, 7) == 0) lb = ~lb;
      if ($urandom_range(0, 7) == 0) ext = ~ext;
      mwe = ($urandom_range(0, 24) == 0);
      mwd = 4'($urandom_range(0, 15));
    end
    @(negedge clk); smp = 0; mwe = 0; ies = 0; iec = 0;
    cyc(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule